// File: doc/BRIEF.md
# Head Positioning Step Sequencer

This block moves a floppy-style read/write head between tracks. It takes a one-byte positioning command and runs one of five operations: return to track zero, seek to a target track, single step in the last direction, single step inward, or single step outward. It produces step pulses and a direction level for the drive mechanism. It keeps the track register, and it reports busy, seek-error, track-zero and head-loaded status in a status byte.

All five operations run on one shared engine. Fields in the command byte control it: a head-load flag, a verify flag, a two-bit step-rate select and, for the single steps, a track-update flag. Every step is a fixed-width high pulse followed by the selected interval, and the engine decides again before each further step. With verify enabled, the engine waits a head-settle delay once stepping ends. It then waits for an external pass or fail indication, which stands in for reading a sector ID on the destination track.

Top module: `head_step_seq`

## Requirements
- R1: A command is accepted only when idle and `cmd_valid` is high. Bytes with bit 7 set start nothing. `cmd_valid` while busy is ignored. The track register changes only while busy.
- R2: Status bit 0 (busy) rises on the clock edge that accepts a command and stays high until the edge that completes it.
- R3: Status bit 5 (head loaded) takes command bit 3 on the accepting edge and holds that value after the command ends.
- R4: Each step drives `step_pulse` high for exactly PULSE_W cycles, then low for the selected interval, then one decision cycle before any next step.
- R5: Command bits 1:0 select the low interval after a pulse: 0 gives RATE0, 1 gives RATE1, 2 gives RATE2 and 3 gives RATE3 cycles.
- R6: Return-to-zero (bits 7:4 = 0000) steps with `dir_in` low until `trk0` is seen at a decision, then sets the track register to 0. It issues no step if `trk0` is already high.
- R7: If return-to-zero has issued MAX_RESTORE steps (default 255) without seeing `trk0`, it ends with status bit 4 (seek error) set and skips verify.
- R8: Seek (bits 7:4 = 0001) compares the track register with `target`. While they differ it steps toward the target, with `dir_in` high when the target is greater, and moves the track register by one at each pulse.
- R9: Step-in (bits 7:5 = 010) and step-out (bits 7:5 = 011) issue one pulse with `dir_in` high or low. When bit 4 is 1 the track register moves by +1 or -1, saturating at 0 and 255. When bit 4 is 0 it is unchanged.
- R10: Plain step (bits 7:5 = 001) issues one pulse in the direction of the most recent step-in or step-out, inward after reset. Bit 4 controls the track update as in R9.
- R11: With command bit 2 set, once stepping ends the sequencer waits SETTLE cycles. It then waits for `vfy_pass` or `vfy_fail`. A fail ends the command with status bit 4 set. A pass ends it with bit 4 clear. Bit 4 is cleared at every accepted command.
- R12: Status bit 2 follows the `trk0` input. Status bits 1, 3, 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd | input | 8 | Positioning command byte |
| target | input | 8 | Destination track for seek |
| trk0 | input | 1 | Head is at track zero |
| vfy_pass | input | 1 | Verify found the expected track |
| vfy_fail | input | 1 | Verify did not find the expected track |
| step_pulse | output | 1 | Step pulse to the drive |
| dir_in | output | 1 | Step direction, 1 = toward higher tracks |
| track | output | 8 | Track register |
| status | output | 8 | Bit 0 busy, bit 2 track zero, bit 4 seek error, bit 5 head loaded |

## Verification
The assertions take for granted that the verify response arrives only as a single-cycle pulse while the sequencer is waiting for it. They also take for granted that `trk0` only changes between step decisions, as a real sensor would after the head moves. The stimulus raises `vfy_pass` or `vfy_fail` only after the settle delay has gone by, and never both together. It drives `trk0` from a modelled head position that moves on each rising step pulse, with a switch that hides track zero to force the return-to-zero timeout. A command byte is injected while a seek is in progress to confirm that it is ignored.

// File: rtl/hss_pkg.sv
package hss_pkg;
  localparam int TRK_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_DECIDE, S_PULSE, S_WAIT, S_SETTLE, S_VERIFY
  } hss_state_e;

  typedef enum logic [2:0] {
    OP_HOME, OP_SEEK, OP_STEP, OP_STEPIN, OP_STEPOUT, OP_NONE
  } hss_op_e;

  typedef struct packed {
    hss_op_e    op;
    logic       upd;
    logic       head;
    logic       vfy;
    logic [1:0] rate;
  } hss_cmd_t;

  function automatic hss_cmd_t hss_decode(input logic [7:0] c);
    hss_cmd_t d;
    d.upd  = c[4];
    d.head = c[3];
    d.vfy  = c[2];
    d.rate = c[1:0];
    case (c[7:5])
      3'b000:  d.op = c[4] ? OP_SEEK : OP_HOME;
      3'b001:  d.op = OP_STEP;
      3'b010:  d.op = OP_STEPIN;
      3'b011:  d.op = OP_STEPOUT;
      default: d.op = OP_NONE;
    endcase
    return d;
  endfunction

  function automatic logic [TRK_W-1:0] hss_track_move(input logic [TRK_W-1:0] t,
                                                     input logic inward);
    if (inward) return (t == {TRK_W{1'b1}}) ? t : t + 1'b1;
    else        return (t == '0) ? t : t - 1'b1;
  endfunction
endpackage

// File: rtl/hss_timer.sv
module hss_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/hss_rate_sel.sv
module hss_rate_sel #(
  parameter int CNT_W = 16,
  parameter int RATE0 = 6,
  parameter int RATE1 = 10,
  parameter int RATE2 = 14,
  parameter int RATE3 = 20
) (
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] cycles
);
  localparam logic [CNT_W-1:0] TAB [4] = '{CNT_W'(RATE0), CNT_W'(RATE1),
                                           CNT_W'(RATE2), CNT_W'(RATE3)};
  assign cycles = TAB[sel];
endmodule

// File: rtl/head_step_seq.sv
module head_step_seq
  import hss_pkg::*;
#(
  parameter int RATE0       = 6,
  parameter int RATE1       = 10,
  parameter int RATE2       = 14,
  parameter int RATE3       = 20,
  parameter int PULSE_W     = 2,
  parameter int SETTLE      = 5,
  parameter int MAX_RESTORE = 255,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd,
  input  logic [TRK_W-1:0] target,
  input  logic             trk0,
  input  logic             vfy_pass,
  input  logic             vfy_fail,
  output logic             step_pulse,
  output logic             dir_in,
  output logic [TRK_W-1:0] track,
  output logic [7:0]       status
);
  localparam int SC_W = $clog2(MAX_RESTORE + 1) + 1;

  hss_state_e       state;
  hss_cmd_t         cur, dec;
  logic [TRK_W-1:0] tgt_q, track_q;
  logic             dir_q, last_dir_q, head_q, err_q;
  logic [SC_W-1:0]  steps_q;

  // named internal events
  logic start, step_fire, finish_fire, abort_fire, vfy_done;
  logic want_step, want_finish, want_abort, step_dir;
  logic busy;

  logic             t_load, t_zero;
  logic [CNT_W-1:0] t_val, rate_cyc;

  assign dec   = hss_decode(cmd);
  assign busy  = (state != S_IDLE);
  assign start = (state == S_IDLE) && cmd_valid && (dec.op != OP_NONE);

  hss_rate_sel #(.CNT_W(CNT_W), .RATE0(RATE0), .RATE1(RATE1),
                 .RATE2(RATE2), .RATE3(RATE3)) u_rate (
    .sel(cur.rate), .cycles(rate_cyc));

  always_comb begin
    want_step   = 1'b0;
    want_finish = 1'b0;
    want_abort  = 1'b0;
    step_dir    = 1'b0;
    unique case (cur.op)
      OP_HOME: begin
        if (trk0)                                   want_finish = 1'b1;
        else if (steps_q == SC_W'(MAX_RESTORE))     want_abort  = 1'b1;
        else                                        want_step   = 1'b1;
      end
      OP_SEEK: begin
        if (track_q == tgt_q) want_finish = 1'b1;
        else begin
          want_step = 1'b1;
          step_dir  = (tgt_q > track_q);
        end
      end
      OP_STEP, OP_STEPIN, OP_STEPOUT: begin
        if (steps_q == '0) begin
          want_step = 1'b1;
          step_dir  = (cur.op == OP_STEP) ? last_dir_q : (cur.op == OP_STEPIN);
        end else want_finish = 1'b1;
      end
      default: want_finish = 1'b1;
    endcase
  end

  assign step_fire   = (state == S_DECIDE) && want_step;
  assign finish_fire = (state == S_DECIDE) && want_finish;
  assign abort_fire  = (state == S_DECIDE) && want_abort;
  assign vfy_done    = (state == S_VERIFY) && (vfy_pass || vfy_fail);

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    if (step_fire) begin
      t_load = 1'b1;
      t_val  = CNT_W'(PULSE_W - 1);
    end else if (state == S_PULSE && t_zero) begin
      t_load = 1'b1;
      t_val  = rate_cyc - 1'b1;
    end else if (finish_fire && cur.vfy) begin
      t_load = 1'b1;
      t_val  = CNT_W'(SETTLE - 1);
    end
  end

  hss_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .val(t_val), .zero(t_zero));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cur        <= '{op: OP_NONE, upd: 1'b0, head: 1'b0, vfy: 1'b0, rate: 2'b00};
      tgt_q      <= '0;
      track_q    <= '0;
      dir_q      <= 1'b0;
      last_dir_q <= 1'b1;
      head_q     <= 1'b0;
      err_q      <= 1'b0;
      steps_q    <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          cur     <= dec;
          tgt_q   <= target;
          head_q  <= dec.head;
          err_q   <= 1'b0;
          steps_q <= '0;
          state   <= S_DECIDE;
        end
        S_DECIDE: begin
          if (step_fire) begin
            dir_q   <= step_dir;
            steps_q <= steps_q + 1'b1;
            if (cur.op == OP_STEPIN)  last_dir_q <= 1'b1;
            if (cur.op == OP_STEPOUT) last_dir_q <= 1'b0;
            if (cur.op == OP_SEEK || (cur.op != OP_HOME && cur.upd))
              track_q <= hss_track_move(track_q, step_dir);
            state <= S_PULSE;
          end else if (abort_fire) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else begin
            if (cur.op == OP_HOME) track_q <= '0;
            state <= cur.vfy ? S_SETTLE : S_IDLE;
          end
        end
        S_PULSE:  if (t_zero) state <= S_WAIT;
        S_WAIT:   if (t_zero) state <= S_DECIDE;
        S_SETTLE: if (t_zero) state <= S_VERIFY;
        S_VERIFY: if (vfy_done) begin
          err_q <= vfy_fail;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign step_pulse = (state == S_PULSE);
  assign dir_in     = dir_q;
  assign track      = track_q;
  assign status     = {2'b00, head_q, err_q, 1'b0, trk0, 1'b0, busy};
endmodule

// File: rtl/hss_chk.sv
module hss_chk #(
  parameter int PULSE_W = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       step_pulse,
  input logic       dir_in,
  input logic [7:0] track,
  input logic [7:0] status,
  input logic       step_fire,
  input logic       abort_fire
);
  logic [15:0] pw_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          pw_cnt <= '0;
    else if (step_pulse) pw_cnt <= pw_cnt + 1'b1;
    else                 pw_cnt <= '0;
  end

  // R4
  step_follows_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> step_pulse);

  // R4
  pulse_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> (pw_cnt < 16'(PULSE_W)));

  // R4
  pulse_full_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(step_pulse) |-> (pw_cnt == 16'(PULSE_W)));

  // R2
  step_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> status[0]);

  // R1
  idle_track_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0] |=> $stable(track));

  // R9
  track_unit_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_pulse) |-> (track == $past(track) || track == $past(track) + 8'd1 ||
                           track == $past(track) - 8'd1));

  // R10
  dir_hold_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pulse && $past(step_pulse)) |-> $stable(dir_in));

  // R11
  err_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> $fell(status[0]));

  // R7
  home_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_fire |=> (!status[0] && status[4]));
endmodule

bind head_step_seq hss_chk #(.PULSE_W(PULSE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_pulse(step_pulse), .dir_in(dir_in),
  .track(track), .status(status), .step_fire(step_fire), .abort_fire(abort_fire));

// File: tb/sim_head_step_seq.sv
module sim_head_step_seq;
  localparam int PW = 2;
  localparam int SETTLE = 5;
  localparam int MAXR = 255;
  localparam int RATES [4] = '{6, 10, 14, 20};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_b = 8'h00, target_b = 8'h00;
  logic vfy_pass = 1'b0, vfy_fail = 1'b0;
  logic trk0;
  logic step_pulse, dir_in;
  logic [7:0] track, status;

  int phys = 3;
  bit cut = 1'b0;
  bit prev_step = 1'b0;
  bit cmp_en = 1'b0;
  bit finished = 1'b0;
  int checks = 0, errors = 0;

  int exp_track = 0, exp_dir = 0, exp_last = 1, exp_head = 0;
  int exp_err = 0, exp_busy = 0, exp_step = 0;

  always #2 clk = ~clk;

  always_comb trk0 = (phys == 0) && !cut;

  head_step_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd_b),
    .target(target_b), .trk0(trk0), .vfy_pass(vfy_pass), .vfy_fail(vfy_fail),
    .step_pulse(step_pulse), .dir_in(dir_in), .track(track), .status(status));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison with the reference model, plus the drive position model
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R4 step_pulse", int'(step_pulse), exp_step);
      chk("R10 dir_in", int'(dir_in), exp_dir);
      chk("R8 track", int'(track), exp_track);
      chk("R2 busy", int'(status[0]), exp_busy);
      chk("R3 head", int'(status[5]), exp_head);
      chk("R11 seek err", int'(status[4]), exp_err);
      chk("R12 trk0 bit", int'(status[2]), int'(trk0));
      chk("R12 zero bits", int'({status[7:6], status[3], status[1]}), 0);
    end
    if (step_pulse && !prev_step) begin
      if (dir_in) phys++;
      else if (phys > 0) phys--;
    end
    prev_step = step_pulse;
  end

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic int sat_move(input int t, input int inward);
    if (inward != 0) return (t >= 255) ? 255 : t + 1;
    return (t <= 0) ? 0 : t - 1;
  endfunction

  task automatic run(input logic [7:0] c, input int tgt, input bit fail,
                     input int rdly, input bit inject);
    int cnt;
    int d;
    int rate;
    bit stp;
    cmd_valid = 1'b1; cmd_b = c; target_b = 8'(tgt);
    tick;
    cmd_valid = 1'b0;
    if (c[7]) begin
      repeat (4) tick;
      return;
    end
    exp_busy = 1; exp_head = int'(c[3]); exp_err = 0;
    cnt = 0; d = 0; rate = RATES[c[1:0]];
    forever begin
      tick;
      stp = 1'b0;
      if (c[7:4] == 4'b0000) begin
        if (trk0) stp = 1'b0;
        else if (cnt == MAXR) begin
          exp_err = 1; exp_busy = 0;
          return;
        end else begin stp = 1'b1; d = 0; end
      end else if (c[7:4] == 4'b0001) begin
        if (exp_track != tgt) begin stp = 1'b1; d = (tgt > exp_track) ? 1 : 0; end
      end else if (cnt == 0) begin
        stp = 1'b1;
        if (c[7:5] == 3'b001) d = exp_last;
        else begin d = (c[7:5] == 3'b010) ? 1 : 0; exp_last = d; end
      end
      if (stp) begin
        exp_step = 1; exp_dir = d;
        if (c[7:4] == 4'b0001 || (c[7:5] != 3'b000 && c[4]))
          exp_track = sat_move(exp_track, d);
        cnt++;
        repeat (PW) begin
          if (inject && cnt == 1) begin cmd_valid = 1'b1; cmd_b = 8'h08; end
          tick;
          cmd_valid = 1'b0;
        end
        exp_step = 0;
        repeat (rate) tick;
      end else begin
        if (c[7:4] == 4'b0000) exp_track = 0;
        if (c[2]) begin
          repeat (SETTLE) tick;
          repeat (rdly) tick;
          if (fail) vfy_fail = 1'b1; else vfy_pass = 1'b1;
          tick;
          vfy_pass = 1'b0; vfy_fail = 1'b0;
          exp_err = fail ? 1 : 0;
        end
        exp_busy = 0;
        return;
      end
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual busy=%0d expected command completion", status[0]);
    finish_run();
  end

  initial begin
    repeat (3) tick;
    chk("R2 reset busy", int'(status[0]), 0);
    chk("R4 reset step", int'(step_pulse), 0);
    chk("R8 reset track", int'(track), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    tick;

    // R1: bytes with bit 7 set start nothing
    run(8'h80, 0, 0, 0, 0);
    chk("R1 ignored 0x80 busy", int'(status[0]), 0);
    run(8'hD0, 0, 0, 0, 0);
    chk("R1 ignored 0xD0 track", int'(track), 0);

    // R6: return to zero from physical track 3, head load, rate 0
    run(8'h08, 0, 0, 0, 0);
    tick;
    chk("R6 home track", int'(track), 0);
    chk("R6 home dir out", int'(dir_in), 0);
    chk("R3 head loaded", int'(status[5]), 1);

    // R10: plain step after reset goes inward
    run(8'h30, 0, 0, 0, 0);
    tick;
    chk("R10 reset direction inward", int'(dir_in), 1);
    chk("R10 plain step track", int'(track), 1);

    // R9: step out to 0 then saturate
    run(8'h70, 0, 0, 0, 0);
    run(8'h70, 0, 0, 0, 0);
    tick;
    chk("R9 step out saturates", int'(track), 0);
    chk("R3 head unloaded", int'(status[5]), 0);

    // R8 R11 R1: seek to 5 with verify pass, rate 1, command injected while busy
    run(8'h1D, 5, 0, 0, 1);
    tick;
    chk("R8 seek reached target", int'(track), 5);
    chk("R11 verify pass no error", int'(status[4]), 0);
    chk("R1 injected command ignored", phys, 5);

    // R9 R5: step in with update, rate 2
    run(8'h52, 0, 0, 0, 0);
    tick;
    chk("R9 step in track", int'(track), 6);

    // R10: plain step follows inward
    run(8'h30, 0, 0, 0, 0);
    tick;
    chk("R10 plain inward", int'(track), 7);

    // R9 R5: step out without update, rate 3
    run(8'h63, 0, 0, 0, 0);
    tick;
    chk("R9 no update track", int'(track), 7);
    chk("R9 step out dir", int'(dir_in), 0);

    // R10: plain step now outward
    run(8'h30, 0, 0, 0, 0);
    tick;
    chk("R10 plain outward", int'(track), 6);

    // R11: seek down to 2, verify fails after a delay
    run(8'h14, 2, 1, 3, 0);
    tick;
    chk("R8 seek down track", int'(track), 2);
    chk("R11 verify fail error", int'(status[4]), 1);

    // R7: track zero hidden, timeout after MAXR steps, verify skipped
    cut = 1'b1;
    run(8'h0C, 0, 0, 0, 0);
    tick;
    chk("R7 timeout error", int'(status[4]), 1);
    chk("R7 timeout idle", int'(status[0]), 0);
    chk("R7 track kept", int'(track), 2);
    cut = 1'b0;
    tick;

    // R6: return to zero with track zero already seen
    run(8'h00, 0, 0, 0, 0);
    tick;
    chk("R6 home immediate track", int'(track), 0);
    chk("R11 error cleared at start", int'(status[4]), 0);

    repeat (4) tick;
    finish_run();
  end
endmodule